// File: doc/BRIEF.md
# Lookup Table Indirect Access Port

This block lets software reach a 68-bit-wide address lookup table through a narrow 32-bit register bus. The table sits in a synchronous single-port RAM outside the block, and software never addresses it directly. Instead it fills three 32-bit staging words, then writes an entry index into an index register. Bit 31 of that index write picks the direction. When set, the staged words are committed to the addressed entry. When clear, the addressed entry is fetched into the staging words, where software reads it back.

The staging words run in reverse order of significance. The lowest staging offset carries the four most significant entry bits, and the highest offset carries the least significant 32 bits. A version register reports the revision. A clear command wipes the whole table by writing zeros one entry per clock, and the bus is stalled until that sweep ends.

The bus holds a request until `bus_ready` is seen high at a clock edge. A transfer takes effect only on such an edge. Read data is registered and appears one cycle after the read is accepted.

Top module: `lut_window`

## Requirements
- R1: After reset `bus_ready` is 1, `bus_rdata`, `tbl_rd_en` and `tbl_wr_en` are 0, and all three staging words read 0.
- R2: A read of offset 0x00 returns the major revision in bits 15:8, the minor revision in bits 7:0 and zeros above; writes to it have no effect.
- R3: Staging words at offsets 0x34, 0x38 and 0x3C read back what was written, except that 0x34 keeps only bits 3:0 and reads zeros in bits 31:4.
- R4: A write to offset 0x20 with bit 31 = 1 and an index (bits 30:0) below DEPTH drives `tbl_wr_en` high for exactly one cycle, starting the cycle after acceptance. During that cycle `tbl_addr` is the index and `tbl_wdata` is {word 0x34 bits 3:0, word 0x38, word 0x3C}, most significant first. The write does not stall the bus.
- R5: A write to offset 0x20 with bit 31 = 0 and an index below DEPTH pulses `tbl_rd_en` for one cycle at that index and holds `bus_ready` low for exactly two cycles. The staging words are then loaded as follows: entry bits 67:64 to 0x34, bits 63:32 to 0x38 and bits 31:0 to 0x3C.
- R6: When the index is DEPTH or more, a commit produces no table write, and a fetch produces no table read and loads zeros into all three staging words.
- R7: A write to offset 0x08 with bit 30 = 1 writes zero to every entry, at addresses 0 to DEPTH-1 in ascending order, one per cycle, over DEPTH consecutive cycles. `bus_ready` stays low throughout the sweep and is high again in the cycle after the last write.
- R8: A request presented while `bus_ready` is low is not accepted: if it is withdrawn before `bus_ready` rises, the staging words remain unchanged.
- R9: Offset 0x20 reads back the last index written in bits 30:0, with bit 31 as 0. Unmapped offsets read as 0. Read data appears in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register transfer request, held until accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Transfer accepted on an edge where request and ready are both high |
| tbl_addr | output | clog2(DEPTH) | Table RAM entry address |
| tbl_rd_en | output | 1 | Table RAM read enable (data one cycle later) |
| tbl_wr_en | output | 1 | Table RAM write enable |
| tbl_wdata | output | 68 | Table RAM write data |
| tbl_rdata | input | 68 | Table RAM read data |

## Verification
Two functions can fall in the same cycle. In the first, a commit's RAM write is still in flight in the cycle where a fetch of the same index is accepted. The bench provokes this by issuing the fetch immediately after the commit, with no idle cycle between them. It then judges the fetched words against the newly committed value, not the old one. In the second, a staging write arrives while the clear sweep is stalling the bus. The bench presents it in the middle of the sweep, withdraws it, and confirms both that the sweep ran undisturbed and that the staging word kept its earlier value.

// File: rtl/lut_window_pkg.sv
package lut_window_pkg;

  localparam int ENTRY_W = 68;
  localparam int DATA_W  = 32;
  localparam int TOP_W   = ENTRY_W - 2 * DATA_W;

  // register byte offsets
  localparam int OFS_ID   = 'h00;
  localparam int OFS_CTL  = 'h08;
  localparam int OFS_IDX  = 'h20;
  localparam int OFS_STG0 = 'h34;
  localparam int OFS_STG1 = 'h38;
  localparam int OFS_STG2 = 'h3C;

  localparam int COMMIT_BIT = 31;
  localparam int CLEAR_BIT  = 30;
  localparam int IDXF_W     = 31;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RD_ISSUE,
    SQ_RD_LAND,
    SQ_SWEEP
  } seq_state_e;

  typedef struct packed {
    logic id;
    logic ctl;
    logic idx;
    logic stg0;
    logic stg1;
    logic stg2;
  } reg_hit_t;

  function automatic logic [ENTRY_W-1:0] join_words(
    input logic [TOP_W-1:0]  top,
    input logic [DATA_W-1:0] mid,
    input logic [DATA_W-1:0] low
  );
    return {top, mid, low};
  endfunction

endpackage

// File: rtl/lut_window_decode.sv
module lut_window_decode
  import lut_window_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);

  always_comb begin
    hit      = '0;
    hit.id   = (addr == ADDR_W'(OFS_ID));
    hit.ctl  = (addr == ADDR_W'(OFS_CTL));
    hit.idx  = (addr == ADDR_W'(OFS_IDX));
    hit.stg0 = (addr == ADDR_W'(OFS_STG0));
    hit.stg1 = (addr == ADDR_W'(OFS_STG1));
    hit.stg2 = (addr == ADDR_W'(OFS_STG2));
  end

endmodule

// File: rtl/lut_window_stage.sv
module lut_window_stage
  import lut_window_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  reg_hit_t           hit,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               load_en,
  input  logic [ENTRY_W-1:0] load_entry,
  output logic [TOP_W-1:0]   w_top,
  output logic [DATA_W-1:0]  w_mid,
  output logic [DATA_W-1:0]  w_low
);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_top <= '0;
      w_mid <= '0;
      w_low <= '0;
    end else if (load_en) begin
      w_top <= load_entry[ENTRY_W-1 -: TOP_W];
      w_mid <= load_entry[2*DATA_W-1 -: DATA_W];
      w_low <= load_entry[DATA_W-1:0];
    end else if (wr_stb) begin
      if (hit.stg0) w_top <= wdata[TOP_W-1:0];
      if (hit.stg1) w_mid <= wdata;
      if (hit.stg2) w_low <= wdata;
    end
  end

  // R5
  load_excl_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !wr_stb);

endmodule

// File: rtl/lut_window_seq.sv
module lut_window_seq
  import lut_window_pkg::*;
#(
  parameter int DEPTH = 48,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_read,
  input  logic               go_commit,
  input  logic               go_clear,
  input  logic [IDXF_W-1:0]  idx_in,
  input  logic [ENTRY_W-1:0] commit_data,
  input  logic [ENTRY_W-1:0] tbl_rdata,
  output logic               idle,
  output logic [IDX_W-1:0]   tbl_addr,
  output logic               tbl_rd_en,
  output logic               tbl_wr_en,
  output logic [ENTRY_W-1:0] tbl_wdata,
  output logic               load_en,
  output logic [ENTRY_W-1:0] load_entry
);

  seq_state_e state_q;
  logic       in_range;
  logic       fetch_ok_q;

  assign in_range   = (idx_in < IDXF_W'(DEPTH));
  assign idle       = (state_q == SQ_IDLE);
  assign load_en    = (state_q == SQ_RD_LAND);
  assign load_entry = fetch_ok_q ? tbl_rdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      tbl_addr   <= '0;
      tbl_rd_en  <= 1'b0;
      tbl_wr_en  <= 1'b0;
      tbl_wdata  <= '0;
      fetch_ok_q <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          tbl_wr_en <= 1'b0;
          tbl_rd_en <= 1'b0;
          if (go_clear) begin
            state_q   <= SQ_SWEEP;
            tbl_addr  <= '0;
            tbl_wdata <= '0;
            tbl_wr_en <= 1'b1;
          end else if (go_read) begin
            state_q    <= SQ_RD_ISSUE;
            tbl_addr   <= idx_in[IDX_W-1:0];
            tbl_rd_en  <= in_range;
            fetch_ok_q <= in_range;
          end else if (go_commit && in_range) begin
            tbl_addr  <= idx_in[IDX_W-1:0];
            tbl_wdata <= commit_data;
            tbl_wr_en <= 1'b1;
          end
        end
        SQ_RD_ISSUE: begin
          tbl_rd_en <= 1'b0;
          state_q   <= SQ_RD_LAND;
        end
        SQ_RD_LAND: begin
          state_q <= SQ_IDLE;
        end
        SQ_SWEEP: begin
          if (int'(tbl_addr) == DEPTH - 1) begin
            tbl_wr_en <= 1'b0;
            state_q   <= SQ_IDLE;
          end else begin
            tbl_addr <= tbl_addr + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // R4 R5
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(tbl_rd_en && tbl_wr_en));

  // R5
  rd_stall_chk: assert property (@(posedge clk) disable iff (rst)
    tbl_rd_en |-> !idle);

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tbl_rd_en || tbl_wr_en) |-> (int'(tbl_addr) < DEPTH));

  // R7
  sweep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SWEEP) |-> (tbl_wr_en && tbl_wdata == '0));

  // R7
  sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SQ_SWEEP && $past(state_q) == SQ_SWEEP)
      |-> tbl_addr == $past(tbl_addr) + 1'b1);

endmodule

// File: rtl/lut_window.sv
module lut_window
  import lut_window_pkg::*;
#(
  parameter int          DEPTH     = 48,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REV_MAJOR = 8'd1,
  parameter logic [7:0]  REV_MINOR = 8'd3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_ready,
  output logic [$clog2(DEPTH)-1:0]    tbl_addr,
  output logic                        tbl_rd_en,
  output logic                        tbl_wr_en,
  output logic [67:0]                 tbl_wdata,
  input  logic [67:0]                 tbl_rdata
);

  reg_hit_t           hit;
  logic               acc_wr;
  logic               acc_rd;
  logic               go_read;
  logic               go_commit;
  logic               go_clear;
  logic               load_en;
  logic [ENTRY_W-1:0] load_entry;
  logic [TOP_W-1:0]   w_top;
  logic [DATA_W-1:0]  w_mid;
  logic [DATA_W-1:0]  w_low;
  logic [IDXF_W-1:0]  idx_shadow;
  logic [DATA_W-1:0]  rd_mux;

  lut_window_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .hit  (hit)
  );

  assign acc_wr    = bus_req && bus_we && bus_ready;
  assign acc_rd    = bus_req && !bus_we && bus_ready;
  assign go_clear  = acc_wr && hit.ctl && bus_wdata[CLEAR_BIT];
  assign go_read   = acc_wr && hit.idx && !bus_wdata[COMMIT_BIT];
  assign go_commit = acc_wr && hit.idx && bus_wdata[COMMIT_BIT];

  lut_window_stage u_stage (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (acc_wr),
    .hit        (hit),
    .wdata      (bus_wdata),
    .load_en    (load_en),
    .load_entry (load_entry),
    .w_top      (w_top),
    .w_mid      (w_mid),
    .w_low      (w_low)
  );

  lut_window_seq #(.DEPTH(DEPTH)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .go_read     (go_read),
    .go_commit   (go_commit),
    .go_clear    (go_clear),
    .idx_in      (bus_wdata[IDXF_W-1:0]),
    .commit_data (join_words(w_top, w_mid, w_low)),
    .tbl_rdata   (tbl_rdata),
    .idle        (bus_ready),
    .tbl_addr    (tbl_addr),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wdata   (tbl_wdata),
    .load_en     (load_en),
    .load_entry  (load_entry)
  );

  always_ff @(posedge clk) begin
    if (rst) idx_shadow <= '0;
    else if (acc_wr && hit.idx) idx_shadow <= bus_wdata[IDXF_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (hit.id)   rd_mux = {16'h0000, REV_MAJOR, REV_MINOR};
    if (hit.idx)  rd_mux = {1'b0, idx_shadow};
    if (hit.stg0) rd_mux = {{(DATA_W-TOP_W){1'b0}}, w_top};
    if (hit.stg1) rd_mux = w_mid;
    if (hit.stg2) rd_mux = w_low;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (acc_rd) bus_rdata <= rd_mux;
  end

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && bus_addr == ADDR_W'(OFS_ID))
      |=> bus_rdata == {16'h0000, REV_MAJOR, REV_MINOR});

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_ready && !load_en) |=> ($stable(w_mid) && $stable(w_low) && $stable(w_top)));

endmodule

// File: tb/lut_window_tb.sv
module lut_window_tb;

  localparam int DEPTH = 48;
  localparam int IW    = $clog2(DEPTH);
  localparam int NV    = 5;
  localparam logic [73:0] VEC [NV] = '{
    {6'd0,  68'hF_1234_5678_9ABC_DEF0},
    {6'd47, 68'hA_DEAD_BEEF_0BAD_F00D},
    {6'd13, 68'h5_0000_0001_8000_0000},
    {6'd1,  68'h0_FFFF_FFFF_FFFF_FFFF},
    {6'd30, 68'h3_C3C3_C3C3_5A5A_5A5A}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [IW-1:0] tbl_addr;
  logic        tbl_rd_en;
  logic        tbl_wr_en;
  logic [67:0] tbl_wdata;
  logic [67:0] tbl_rdata;

  logic [67:0] mem [64];
  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  lut_window #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .tbl_addr(tbl_addr), .tbl_rd_en(tbl_rd_en),
    .tbl_wr_en(tbl_wr_en), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
  );

  // table RAM model, one cycle read latency
  always @(posedge clk) begin
    if (tbl_wr_en) mem[tbl_addr] <= tbl_wdata;
    if (tbl_rd_en) tbl_rdata <= mem[tbl_addr];
  end

  always @(negedge clk) if (tbl_wr_en) wr_cnt++;

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // called at a negedge, returns at the negedge after acceptance
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_req = 1; bus_we = 0; bus_addr = a;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_req = 0;
  endtask

  task automatic fetch_check(input string tag, input int idx, input logic [67:0] exp);
    logic [31:0] r0, r1, r2;
    bus_write(8'h20, 32'(idx));
    bus_read(8'h34, r0);
    bus_read(8'h38, r1);
    bus_read(8'h3C, r2);
    chk(tag, {r0[3:0], r1, r2}, exp);
    chk({tag, " w0 upper"}, 68'(r0[31:4]), 68'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int w0;
    int errs;
    for (int i = 0; i < 64; i++) mem[i] = {4'h9, 64'h5A5A_5A5A_0000_0000} | 68'(i);
    tbl_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 68'(bus_ready), 68'h1);
    chk("R1 rdata", 68'(bus_rdata), 68'h0);
    chk("R1 rd/wr en", 68'({tbl_rd_en, tbl_wr_en}), 68'h0);
    bus_read(8'h38, r);
    chk("R1 staging mid", 68'(r), 68'h0);

    // R2 version register, write ignored
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, r);
    chk("R2 id", 68'(r), 68'h0000_0103);

    // R3 staging mask
    bus_write(8'h34, 32'hFFFF_FFF6);
    bus_read(8'h34, r);
    chk("R3 word0 mask", 68'(r), 68'h6);

    // R4 table walk: stage, commit, inspect RAM port
    for (int v = 0; v < NV; v++) begin
      logic [67:0] e;
      int ix;
      e  = VEC[v][67:0];
      ix = int'(VEC[v][73:68]);
      bus_write(8'h34, {28'h0, e[67:64]});
      bus_write(8'h38, e[63:32]);
      bus_write(8'h3C, e[31:0]);
      bus_write(8'h20, 32'h8000_0000 | 32'(ix));
      chk("R4 commit port", {tbl_wr_en, tbl_addr, tbl_wdata}, {1'b1, IW'(ix), e} );
      chk("R4 no stall", 68'(bus_ready), 68'h1);
      @(negedge clk);
      chk("R4 single pulse", 68'(tbl_wr_en), 68'h0);
    end
    // R5 fetch back in a different order, with word mapping
    for (int v = NV - 1; v >= 0; v--)
      fetch_check("R5 fetch", int'(VEC[v][73:68]), VEC[v][67:0]);

    // R5 fetch timing: ready low exactly two cycles
    bus_write(8'h20, 32'd13);
    chk("R5 rd pulse/stall c1", 68'({tbl_rd_en, bus_ready, tbl_addr}), {61'h0, 1'b1, 1'b0, IW'(13)});
    @(negedge clk);
    chk("R5 stall c2", 68'({tbl_rd_en, bus_ready}), 68'h0);
    @(negedge clk);
    chk("R5 ready back", 68'(bus_ready), 68'h1);

    // R9 index readback and unmapped offset
    bus_read(8'h20, r);
    chk("R9 idx readback", 68'(r), 68'd13);
    bus_read(8'h44, r);
    chk("R9 unmapped", 68'(r), 68'h0);

    // R6 out of range commit and fetch
    w0 = wr_cnt;
    bus_write(8'h20, 32'h8000_0032);
    @(negedge clk);
    chk("R6 no write", 68'(wr_cnt - w0), 68'h0);
    chk("R6 mem untouched", mem[50], {4'h9, 64'h5A5A_5A5A_0000_0000} | 68'd50);
    bus_write(8'h20, 32'd50);
    chk("R6 no read", 68'(tbl_rd_en), 68'h0);
    fetch_check("R6 zero load", 50, 68'h0);

    // R4 R5 commit followed at once by fetch of the same index
    bus_write(8'h34, 32'h7);
    bus_write(8'h38, 32'h1357_9BDF);
    bus_write(8'h3C, 32'h2468_ACE0);
    bus_write(8'h20, 32'h8000_0007);
    fetch_check("R4 R5 back-to-back", 7, 68'h7_1357_9BDF_2468_ACE0);

    // R7 clear sweep, with R8 stalled staging write inside it
    bus_write(8'h34, 32'h9);
    w0 = wr_cnt;
    errs = 0;
    bus_write(8'h08, 32'h4000_0000);
    for (int k = 0; k < DEPTH; k++) begin
      if (!(tbl_wr_en && int'(tbl_addr) == k && tbl_wdata == '0 && !bus_ready)) errs++;
      if (k == 5) begin bus_req = 1; bus_we = 1; bus_addr = 8'h34; bus_wdata = 32'h2; end
      if (k == 6) begin bus_req = 0; bus_we = 0; end
      @(negedge clk);
    end
    chk("R7 sweep order", 68'(errs), 68'h0);
    chk("R7 sweep length", 68'(wr_cnt - w0), 68'(DEPTH));
    chk("R7 ready after", 68'({bus_ready, tbl_wr_en}), 68'h2);
    errs = 0;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != '0) errs++;
    chk("R7 table zero", 68'(errs), 68'h0);
    bus_read(8'h34, r);
    chk("R8 stalled write ignored", 68'(r), 68'h9);
    fetch_check("R7 fetch cleared", 47, 68'h0);

    finish_run();
  end

endmodule